// File: doc/BRIEF.md
# Early-Terminating Long Multiplier

This unit sits beside the ALU in a small processor's execute stage and handles every integer multiply flavour. It offers a 32-bit low-word product and two 32-bit accumulate forms, one adding and one subtracting. It also offers the full 64-bit product, signed or unsigned, with or without a 64-bit addend. The 32-bit forms have a fixed, short latency. The 64-bit forms consume the multiplier operand one byte per clock. They stop as soon as the bytes still unprocessed carry no information, so small operands return sooner.

The pipeline issues an operation with a one-cycle `start` pulse while `busy` is low. It then waits for the one-cycle `done` pulse, at which point `result` holds the answer. If an interrupt must be taken, the pipeline raises `abort`. The unit then drops the operation in progress on the next edge without producing an answer, and the instruction can later be reissued from scratch.

Top module: `early_term_mul`

## Requirements
- R1: With op code 0 (low multiply), `result` is the low 32 bits of `a*b` with bits 63:32 zero, and `done` is high in the cycle right after the edge that accepts `start`; `busy` stays low.
- R2: Op code 1 (add-accumulate) returns `acc[31:0] + low32(a*b)`; op code 2 (subtract-accumulate) returns `acc[31:0] - low32(a*b)`. Both wrap at 32 bits, have bits 63:32 zero, and raise `done` one cycle later than op code 0.
- R3: Op code 3 (long multiply) returns the full 64-bit product, with both operands read as two's complement when `sgn` is 1 and as unsigned when `sgn` is 0.
- R4: Op code 4 (long multiply-accumulate) returns that 64-bit product plus the 64-bit `acc`, wrapping at 64 bits.
- R5: Take n as the smallest value in {2,3,4} such that `b` fits in n bytes. Unsigned means `b < 2^(8n)`; signed means `-2^(8n-1) <= b < 2^(8n-1)`. The latency of op code 3, counting the accepting edge as 1, is n+1 cycles: 3 to 5.
- R6: The latency of op code 4 is n+2 cycles: 4 to 6.
- R7: For op codes 1 to 4, `busy` is high from the accepting edge until the edge that raises `done`. `done` lasts one cycle, and `busy` is low while it is high.
- R8: If `abort` is high at an edge while `busy` is high, `busy` is low after that edge. No `done` pulse follows for that operation, and `result` keeps its previous value. A reissued operation completes normally.
- R9: `start` while `busy` is high is ignored: the running operation's result and latency are unchanged.
- R10: `result` changes only in a cycle in which `done` is high, so it holds from the `done` pulse until a later operation completes.
- R11: After reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issue pulse, taken when `busy` is low |
| op | input | 3 | 0 low mul, 1 add-acc, 2 sub-acc, 3 long mul, 4 long mul-acc; 5 to 7 act as 3 |
| sgn | input | 1 | 1 = signed operands for the long forms |
| a | input | 32 | Multiplicand |
| b | input | 32 | Multiplier, consumed a byte per cycle by the long forms |
| acc | input | 64 | Addend; bits 31:0 only for op codes 1 and 2 |
| abort | input | 1 | Drop the operation in progress |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Answer, held between completions |

## Verification
Random operands are drawn with the multiplier trimmed to one, two, three or four significant bytes, and sometimes sign-inverted. This moves early termination across every possible stop point, so a wrong span rule shows up as a latency error even when the arithmetic is right. Directed cases sit exactly on the byte boundaries, such as 0x7FFF against 0x8000 signed and 0x00FFFFFF against 0x01000000 unsigned. They also use all-ones operands, which separate signed from unsigned handling of the final byte. Accumulate cases with carries across bit 31 and bit 63, and a subtract that goes negative, separate 32-bit from 64-bit wrap. Aborts at different points in a long operation, and a stray `start` during a long operation, show whether the control path lets an old or a foreign operation leak into `result`.

// File: rtl/etm_pkg.sv
package etm_pkg;

  localparam int unsigned OPW    = 32;            // operand width
  localparam int unsigned CHW    = 8;             // multiplier bits per step
  localparam int unsigned MIN_CH = 2;             // steps always taken
  localparam int unsigned PW     = 2 * OPW;       // product width
  localparam int unsigned NCH    = OPW / CHW;     // steps for a full operand
  localparam int unsigned CNT_W  = $clog2(NCH + 1);
  localparam int unsigned IDX_W  = $clog2(NCH);

  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_MLA  = 3'd1,
    OP_MLS  = 3'd2,
    OP_LMUL = 3'd3,
    OP_LMAC = 3'd4
  } etm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ITER,
    ST_ACC,
    ST_SHORT
  } etm_state_e;

  // Widen the multiplicand to product width.
  function automatic logic [PW-1:0] widen(input logic [OPW-1:0] v, input logic s);
    return s ? {{OPW{v[OPW-1]}}, v} : {{OPW{1'b0}}, v};
  endfunction

  // Smallest number of multiplier steps that still represents b exactly.
  function automatic logic [CNT_W-1:0] steps_needed(input logic [OPW-1:0] b, input logic s);
    logic [CNT_W-1:0] n;
    logic [OPW-1:0]   rest;
    n = CNT_W'(NCH);
    for (int k = NCH - 1; k >= int'(MIN_CH); k--) begin
      if (s) begin
        rest = OPW'($signed(b) >>> (k * CHW - 1));
        if (rest == '0 || rest == '1) n = CNT_W'(k);
      end else begin
        rest = b >> (k * CHW);
        if (rest == '0) n = CNT_W'(k);
      end
    end
    return n;
  endfunction

  // Weighted contribution of one multiplier slice.
  function automatic logic [PW-1:0] slice_term(input logic [PW-1:0] a_w,
                                               input logic [CHW-1:0] slice,
                                               input logic top_signed,
                                               input logic [IDX_W-1:0] pos);
    logic [PW-1:0] m;
    m = top_signed ? {{(PW-CHW){slice[CHW-1]}}, slice} : {{(PW-CHW){1'b0}}, slice};
    return (a_w * m) << (int'(pos) * CHW);
  endfunction

  // Low-word accumulate forms.
  function automatic logic [OPW-1:0] low_combine(input logic [2:0] code,
                                                 input logic [OPW-1:0] addend,
                                                 input logic [OPW-1:0] plow);
    return (code == OP_MLS) ? addend - plow : addend + plow;
  endfunction

endpackage

// File: rtl/etm_span.sv
module etm_span
  import etm_pkg::*;
(
  input  logic [OPW-1:0]   b,
  input  logic             sgn,
  output logic [IDX_W-1:0] last_idx
);
  logic [CNT_W-1:0] n_steps;

  always_comb begin
    n_steps  = steps_needed(b, sgn);
    last_idx = IDX_W'(n_steps - CNT_W'(1));
  end
endmodule

// File: rtl/etm_lowmul.sv
module etm_lowmul
  import etm_pkg::*;
(
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  output logic [OPW-1:0] p_low
);
  always_comb p_low = a * b;
endmodule

// File: rtl/etm_step.sv
module etm_step
  import etm_pkg::*;
(
  input  logic [PW-1:0]    a_w,
  input  logic [OPW-1:0]   b,
  input  logic [IDX_W-1:0] pos,
  input  logic             top_signed,
  input  logic [PW-1:0]    sum_in,
  output logic [PW-1:0]    sum_out
);
  logic [CHW-1:0] slices [NCH];
  logic [CHW-1:0] cur;

  for (genvar g = 0; g < NCH; g++) begin : g_slice
    assign slices[g] = b[g*CHW +: CHW];
  end

  always_comb begin
    cur     = slices[pos];
    sum_out = sum_in + slice_term(a_w, cur, top_signed, pos);
  end
endmodule

// File: rtl/early_term_mul.sv
module early_term_mul
  import etm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic             sgn,
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  input  logic [PW-1:0]    acc,
  input  logic             abort,
  output logic             busy,
  output logic             done,
  output logic [PW-1:0]    result
);

  etm_state_e       state_q;
  logic [2:0]       op_q;
  logic             sgn_q;
  logic [PW-1:0]    a_q;
  logic [OPW-1:0]   b_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  logic [PW-1:0]    sum_q;
  logic [PW-1:0]    acc_q;
  logic [PW-1:0]    res_q;
  logic             done_q;

  // named internal events
  logic             accept_w;
  logic             final_step_w;
  logic [IDX_W-1:0] span_last_w;
  logic [OPW-1:0]   p_low_w;
  logic [PW-1:0]    sum_next_w;

  etm_span u_span (
    .b        (b),
    .sgn      (sgn),
    .last_idx (span_last_w)
  );

  etm_lowmul u_lowmul (
    .a     (a),
    .b     (b),
    .p_low (p_low_w)
  );

  etm_step u_step (
    .a_w        (a_q),
    .b          (b_q),
    .pos        (idx_q),
    .top_signed (sgn_q && final_step_w),
    .sum_in     (sum_q),
    .sum_out    (sum_next_w)
  );

  always_comb begin
    accept_w     = start && (state_q == ST_IDLE);
    final_step_w = (idx_q == last_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      sgn_q   <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      sum_q   <= '0;
      acc_q   <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q != ST_IDLE && abort) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (accept_w) begin
              op_q  <= op;
              sgn_q <= sgn;
              acc_q <= acc;
              case (op)
                OP_MUL: begin
                  res_q  <= {{OPW{1'b0}}, p_low_w};
                  done_q <= 1'b1;
                end
                OP_MLA, OP_MLS: begin
                  sum_q   <= {{OPW{1'b0}}, p_low_w};
                  state_q <= ST_SHORT;
                end
                default: begin
                  a_q     <= widen(a, sgn);
                  b_q     <= b;
                  idx_q   <= '0;
                  last_q  <= span_last_w;
                  sum_q   <= '0;
                  state_q <= ST_ITER;
                end
              endcase
            end
          end
          ST_ITER: begin
            sum_q <= sum_next_w;
            idx_q <= idx_q + IDX_W'(1);
            if (final_step_w) begin
              if (op_q == OP_LMAC) begin
                state_q <= ST_ACC;
              end else begin
                res_q   <= sum_next_w;
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ACC: begin
            res_q   <= sum_q + acc_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
          ST_SHORT: begin
            res_q   <= {{OPW{1'b0}}, low_combine(op_q, acc_q[OPW-1:0], sum_q[OPW-1:0])};
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;

endmodule

// File: rtl/etm_checker.sv
module etm_checker
  import etm_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          start_ok,
  input logic [2:0]    op_sel,
  input logic [2:0]    op_q,
  input logic          abort,
  input logic          busy,
  input logic          done,
  input logic [PW-1:0] result
);

  assert_mul_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && op_sel == OP_MUL) |=> (done && !busy));

  assert_short_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && (op_sel == OP_MLA || op_sel == OP_MLS)) |=> (busy && !done));

  assert_short_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_MUL || op_q == OP_MLA || op_q == OP_MLS)) |-> (result[PW-1:OPW] == '0));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || $past(abort)));

  assert_abort_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> (!busy && !done));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

endmodule

bind early_term_mul etm_checker u_etm_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_ok (accept_w),
  .op_sel   (op),
  .op_q     (op_q),
  .abort    (abort),
  .busy     (busy),
  .done     (done),
  .result   (result)
);

// File: tb/test_early_term_mul.sv
module test_early_term_mul;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        sgn = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [63:0] acc = '0;
  logic        abort = 1'b0;
  logic        busy;
  logic        done;
  logic [63:0] result;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  early_term_mul i_early_term_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sgn(sgn),
    .a(a), .b(b), .acc(acc), .abort(abort),
    .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference answer, written from the requirements
  function automatic logic [63:0] ref_val(input int code, input logic s, input logic [31:0] x,
                                          input logic [31:0] y, input logic [63:0] ad);
    logic [31:0] lo;
    longint      sp;
    logic [63:0] full;
    lo = x * y;
    if (s) begin
      sp   = longint'($signed(x)) * longint'($signed(y));
      full = sp;
    end else begin
      full = {32'd0, x} * {32'd0, y};
    end
    case (code)
      0: return {32'd0, lo};
      1: return {32'd0, ad[31:0] + lo};
      2: return {32'd0, ad[31:0] - lo};
      4: return full + ad;
      default: return full;
    endcase
  endfunction

  function automatic int ref_lat(input int code, input logic s, input logic [31:0] y);
    int     n;
    longint v;
    if (code == 0) return 1;
    if (code == 1 || code == 2) return 2;
    v = s ? longint'($signed(y)) : longint'({32'd0, y});
    n = 4;
    for (int k = 4; k >= 2; k--) begin
      if (s) begin
        if (v >= -(64'sd1 <<< (8*k-1)) && v < (64'sd1 <<< (8*k-1))) n = k;
      end else begin
        if (v < (64'sd1 <<< (8*k))) n = k;
      end
    end
    return (code == 4) ? n + 2 : n + 1;
  endfunction

  function automatic string lat_req(input int code);
    case (code)
      0: return "R1";
      1, 2: return "R2";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic string val_req(input int code);
    case (code)
      0: return "R1";
      1, 2: return "R2";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  // Issue one operation; a stray start is raised at step `noise_at` (0 = none).
  task automatic run_op(input int code, input logic s, input logic [31:0] x,
                        input logic [31:0] y, input logic [63:0] ad, input int noise_at);
    int          lat;
    logic [63:0] exp;
    exp = ref_val(code, s, x, y, ad);
    @(negedge clk);
    op = 3'(code); sgn = s; a = x; b = y; acc = ad; start = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    if (code == 0) chk("R1 busy stays low", {63'd0, busy}, 64'd0);
    else           chk("R7 busy after accept", {63'd0, busy}, 64'd1);
    while (!done && lat < 20) begin
      if (noise_at != 0 && lat == noise_at) begin
        start = 1'b1; op = 3'd0; a = 32'h1234_5678; b = 32'h9ABC_DEF0; // R9 stray issue
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
    end
    chk(noise_at != 0 ? "R9 result" : val_req(code), result, exp);
    chk(noise_at != 0 ? "R9 latency" : lat_req(code), 64'(lat), 64'(ref_lat(code, s, y)));
    chk("R7 busy low at done", {63'd0, busy}, 64'd0);
    @(negedge clk);
    chk("R10 result held", result, exp);
    chk("R7 done single cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic run_abort(input int code, input logic s, input logic [31:0] x,
                           input logic [31:0] y, input int abort_at);
    logic [63:0] prev;
    prev = result;
    @(negedge clk);
    op = 3'(code); sgn = s; a = x; b = y; acc = 64'hDEAD; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i < abort_at; i++) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R8 busy dropped", {63'd0, busy}, 64'd0);
    for (int i = 0; i < 8; i++) begin
      chk("R8 no done after abort", {63'd0, done}, 64'd0);
      @(negedge clk);
    end
    chk("R8 result kept", result, prev);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 busy", {63'd0, busy}, 64'd0);
    chk("R11 done", {63'd0, done}, 64'd0);
    chk("R11 result", result, 64'd0);

    // directed corners
    run_op(0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 0);
    run_op(1, 1'b0, 32'h8000_0001, 32'h0000_0003, 64'h1_FFFF_FFF0, 0);
    run_op(2, 1'b1, 32'h0000_0010, 32'h0000_0020, 64'h0000_0000_0000_0100, 0);
    run_op(3, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 0);
    run_op(3, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 0);
    run_op(3, 1'b1, 32'h1234_5678, 32'h0000_7FFF, 64'd0, 0);
    run_op(3, 1'b1, 32'h1234_5678, 32'h0000_8000, 64'd0, 0);
    run_op(3, 1'b1, 32'h8765_4321, 32'hFFFF_8000, 64'd0, 0);
    run_op(3, 1'b1, 32'h8765_4321, 32'hFF80_0000, 64'd0, 0);
    run_op(3, 1'b1, 32'h7FFF_FFFF, 32'h8000_0000, 64'd0, 0);
    run_op(3, 1'b0, 32'hCAFE_F00D, 32'h00FF_FFFF, 64'd0, 0);
    run_op(3, 1'b0, 32'hCAFE_F00D, 32'h0100_0000, 64'd0, 0);
    run_op(3, 1'b0, 32'h0000_0005, 32'h0000_0000, 64'd0, 0);
    run_op(4, 1'b0, 32'hFFFF_FFFF, 32'h0000_0002, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run_op(4, 1'b1, 32'h8000_0000, 32'h8000_0000, 64'h8000_0000_0000_0000, 0);

    // stray start during a long operation
    run_op(3, 1'b0, 32'h1111_2222, 32'hF000_0001, 64'd0, 2);
    run_op(4, 1'b1, 32'h3333_4444, 32'h0000_1234, 64'h55, 1);

    // abort at several points, then reissue
    run_abort(3, 1'b0, 32'h0BAD_BEEF, 32'hFFFF_FFFF, 1);
    run_op(3, 1'b0, 32'h0BAD_BEEF, 32'hFFFF_FFFF, 64'd0, 0);
    run_abort(4, 1'b1, 32'h0BAD_BEEF, 32'h8000_0000, 4);
    run_op(4, 1'b1, 32'h0BAD_BEEF, 32'h8000_0000, 64'h77, 0);
    run_abort(1, 1'b0, 32'h2, 32'h3, 1);
    run_op(1, 1'b0, 32'h2, 32'h3, 64'h10, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int          code;
      int          nb;
      logic        s;
      logic [31:0] x;
      logic [31:0] y;
      logic [63:0] ad;
      code = $urandom_range(0, 4);
      s    = 1'($urandom_range(0, 1));
      nb   = $urandom_range(1, 4);
      x    = $urandom;
      y    = $urandom;
      if (nb < 4) y = y & ((32'd1 << (8 * nb)) - 32'd1);
      if (s && $urandom_range(0, 1) == 1) y = ~y;
      ad   = {$urandom, $urandom};
      run_op(code, s, x, y, ad, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule